// File: doc/BRIEF.md
# UART Interrupt Priority and Status Unit

This block collects every interrupt cause of one UART channel, keeps a pending flag for each, masks the flags with the host's enable byte, and presents the most urgent enabled cause as a 6-bit status code. Lower-ranked causes stay pending and surface once the higher ones have been serviced. A registered interrupt request line tells the host that at least one enabled cause is pending.

Each cause has its own set and clear rule. Some clear on a read of a particular register, one follows the receive FIFO fill level, one is cleared by later receive traffic, and the receive idle timeout is timed by a counter inside the block, clocked by a one-cycle bit-time tick. The line, modem, FIFO and flow-control logic around the block supply events and levels. This block does not include the shifters, the FIFOs or the baud generator.

Top module: `uirq_top`

## Requirements
- R1: Enable bits 5 (Xoff/special), 6 (RTS) and 7 (CTS) act only while `ext_en_i` is 1. When `ext_en_i` is 0 those causes are never reported and never raise `irq_o`.
- R2: `isr_o` shows only the highest enabled pending cause. The ranking, from most to least urgent, with codes, is: line status 0x06, receive timeout 0x0C, receive data 0x04, transmit ready 0x02, modem status 0x00, Xoff/special 0x10, RTS/CTS 0x20. Enable bit 0 covers receive data and timeout, bit 1 covers transmit, bit 2 covers line status and bit 3 covers modem status.
- R3: The line-status flag is set by `lsr_evt_i` and cleared by `lsr_rd_i`. If both arrive in the same cycle, the set takes priority.
- R4: The receive-data cause is pending while `rx_lvl_i >= rx_trig_i` (sampled each cycle). It clears only once the level falls below the trigger.
- R5: With the receive FIFO non-empty, the timeout flag sets after 4*CHAR_BITS+12 `bit_tick_i` pulses (52 by default) with no `rx_char_i` and no `rhr_rd_i`. Either of those, or an empty FIFO, restarts the count. Only `rhr_rd_i` clears the flag.
- R6: The transmit flag is set by `tx_evt_i`. It clears on `thr_wr_i`, or on `isr_rd_i` while transmit is the code shown.
- R7: The modem flag is set by `msr_evt_i` and cleared by `msr_rd_i`.
- R8: The Xoff flag clears on `xon_evt_i`. The special-character flag clears on the next `rx_char_i`. Both clear on `isr_rd_i` while code 0x10 is shown. A set in the same cycle takes priority over any clear.
- R9: A low-to-high change on `rts_i` (or `cts_i`) while `auto_rts_i` (or `auto_cts_i`) is 1 sets that pin's flag. Both pins count as previously high at reset. `msr_rd_i` clears both flags.
- R10: `irq_o` is a register that, one cycle later, equals "some enabled cause is pending". Pending flags are kept even while their cause is disabled.
- R11: With nothing enabled and pending, `isr_o` reads 0x01. After reset, `isr_o` is 0x01 and `irq_o` is 0.
- R12: An event sampled at a clock edge is visible on `isr_o` right after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ier_i | input | 8 | Interrupt enable byte |
| ext_en_i | input | 1 | Extended-feature enable |
| lsr_evt_i | input | 1 | Line-status error event (status bits 1..4) |
| lsr_rd_i | input | 1 | Line-status register read |
| rx_lvl_i | input | LVL_W | Receive FIFO occupancy |
| rx_trig_i | input | LVL_W | Receive trigger level |
| rx_char_i | input | 1 | A character entered the receive FIFO |
| rhr_rd_i | input | 1 | Receive holding register read |
| bit_tick_i | input | 1 | One pulse per bit time |
| tx_evt_i | input | 1 | Transmit trigger reached or FIFO emptied |
| thr_wr_i | input | 1 | Transmit holding register write |
| msr_evt_i | input | 1 | Modem-status change (status bits 0..3) |
| msr_rd_i | input | 1 | Modem-status register read |
| xoff_evt_i | input | 1 | Xoff character detected |
| xon_evt_i | input | 1 | Xon character detected |
| spc_evt_i | input | 1 | Special character detected |
| rts_i | input | 1 | RTS pin level |
| cts_i | input | 1 | CTS pin level |
| auto_rts_i | input | 1 | Automatic RTS flow control active |
| auto_cts_i | input | 1 | Automatic CTS flow control active |
| isr_rd_i | input | 1 | Interrupt status register read |
| isr_o | output | 6 | Encoded highest pending cause |
| irq_o | output | 1 | Registered interrupt request |

## Verification
Two kinds of same-cycle collision matter. The first is a status read that lands in the same cycle as a new event for the cause being cleared: a line-status read together with a new line error, and a status read together with a fresh Xoff detection. The bench provokes both directly, and the expected result is that the flag stays set. The second is a status read arriving while several causes are pending. It must clear only the cause on display, so the bench stacks transmit, modem and Xoff events and then reads the codes back in order against a behavioural model that is stepped every clock.

// File: rtl/uirq_pkg.sv
package uirq_pkg;
  typedef enum logic [2:0] {
    SRC_LS, SRC_TO, SRC_RXD, SRC_TX, SRC_MS, SRC_XS, SRC_FC, SRC_NONE
  } src_e;

  localparam int NLVL = 7;
  localparam int NFLAG = 7;
  localparam int F_LS = 0, F_TX = 1, F_MS = 2, F_XOFF = 3, F_SPC = 4, F_RTS = 5, F_CTS = 6;

  localparam logic [5:0] CODE_LS   = 6'h06;
  localparam logic [5:0] CODE_TO   = 6'h0C;
  localparam logic [5:0] CODE_RXD  = 6'h04;
  localparam logic [5:0] CODE_TX   = 6'h02;
  localparam logic [5:0] CODE_MS   = 6'h00;
  localparam logic [5:0] CODE_XS   = 6'h10;
  localparam logic [5:0] CODE_FC   = 6'h20;
  localparam logic [5:0] CODE_NONE = 6'h01;

  function automatic logic [5:0] code_of(src_e s);
    case (s)
      SRC_LS:  return CODE_LS;
      SRC_TO:  return CODE_TO;
      SRC_RXD: return CODE_RXD;
      SRC_TX:  return CODE_TX;
      SRC_MS:  return CODE_MS;
      SRC_XS:  return CODE_XS;
      SRC_FC:  return CODE_FC;
      default: return CODE_NONE;
    endcase
  endfunction
endpackage

// File: rtl/uirq_flag.sv
module uirq_flag (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_i,
  output logic q_o
);
  // set dominates a same-cycle clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    q_o <= 1'b0;
    else if (set_i) q_o <= 1'b1;
    else if (clr_i) q_o <= 1'b0;
  end

  p_set_wins_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_i |=> q_o);
endmodule

// File: rtl/uirq_timeout.sv
module uirq_timeout #(
  parameter int CHAR_BITS = 10
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic nz_i,
  input  logic restart_i,
  input  logic tick_i,
  input  logic rhr_rd_i,
  output logic pend_o
);
  localparam int TO_BITS = 4 * CHAR_BITS + 12;
  localparam int CNT_W   = $clog2(TO_BITS + 1);

  logic [CNT_W-1:0] cnt_q;
  logic             hit;

  assign hit = nz_i && !restart_i && tick_i && (cnt_q == CNT_W'(TO_BITS - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      pend_o <= 1'b0;
    end else begin
      if (restart_i || !nz_i)                        cnt_q <= '0;
      else if (tick_i && cnt_q != CNT_W'(TO_BITS))   cnt_q <= cnt_q + 1'b1;
      if (rhr_rd_i) pend_o <= 1'b0;
      else if (hit) pend_o <= 1'b1;
    end
  end

  p_to_clr_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rhr_rd_i |=> !pend_o);
  p_to_nz_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!pend_o && !rhr_rd_i && !nz_i) |=> !pend_o);
endmodule

// File: rtl/uirq_prio.sv
module uirq_prio
  import uirq_pkg::*;
(
  input  logic [NLVL-1:0] req_i,
  output src_e            src_o,
  output logic [5:0]      code_o
);
  always_comb begin
    src_o = SRC_NONE;
    for (int i = NLVL - 1; i >= 0; i--)
      if (req_i[i]) src_o = src_e'(i);
  end
  assign code_o = code_of(src_o);
endmodule

// File: rtl/uirq_top.sv
module uirq_top
  import uirq_pkg::*;
#(
  parameter int LVL_W     = 7,
  parameter int CHAR_BITS = 10
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [7:0]       ier_i,
  input  logic             ext_en_i,
  input  logic             lsr_evt_i,
  input  logic             lsr_rd_i,
  input  logic [LVL_W-1:0] rx_lvl_i,
  input  logic [LVL_W-1:0] rx_trig_i,
  input  logic             rx_char_i,
  input  logic             rhr_rd_i,
  input  logic             bit_tick_i,
  input  logic             tx_evt_i,
  input  logic             thr_wr_i,
  input  logic             msr_evt_i,
  input  logic             msr_rd_i,
  input  logic             xoff_evt_i,
  input  logic             xon_evt_i,
  input  logic             spc_evt_i,
  input  logic             rts_i,
  input  logic             cts_i,
  input  logic             auto_rts_i,
  input  logic             auto_cts_i,
  input  logic             isr_rd_i,
  output logic [5:0]       isr_o,
  output logic             irq_o
);
  logic [NFLAG-1:0] set_v, clr_v, flag_q;
  logic [NLVL-1:0]  lvl_req;
  logic             rts_d, cts_d, rxd_q, to_q, irq_q;
  logic             en_rx, en_tx, en_ls, en_ms, en_xs, en_rts, en_cts;
  src_e             shown;
  logic             rd_tx, rd_xs;

  // extended enables read as 0 unless the feature bit is on
  assign en_rx  = ier_i[0];
  assign en_tx  = ier_i[1];
  assign en_ls  = ier_i[2];
  assign en_ms  = ier_i[3];
  assign en_xs  = ier_i[5] & ext_en_i;
  assign en_rts = ier_i[6] & ext_en_i;
  assign en_cts = ier_i[7] & ext_en_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rts_d <= 1'b1;
      cts_d <= 1'b1;
      rxd_q <= 1'b0;
      irq_q <= 1'b0;
    end else begin
      rts_d <= rts_i;
      cts_d <= cts_i;
      rxd_q <= (rx_lvl_i >= rx_trig_i);
      irq_q <= |lvl_req;
    end
  end

  assign rd_tx = isr_rd_i && (shown == SRC_TX);
  assign rd_xs = isr_rd_i && (shown == SRC_XS);

  always_comb begin
    set_v = '0;
    clr_v = '0;
    set_v[F_LS]   = lsr_evt_i;                         clr_v[F_LS]   = lsr_rd_i;
    set_v[F_TX]   = tx_evt_i;                          clr_v[F_TX]   = thr_wr_i | rd_tx;
    set_v[F_MS]   = msr_evt_i;                         clr_v[F_MS]   = msr_rd_i;
    set_v[F_XOFF] = xoff_evt_i;                        clr_v[F_XOFF] = xon_evt_i | rd_xs;
    set_v[F_SPC]  = spc_evt_i;                         clr_v[F_SPC]  = rx_char_i | rd_xs;
    set_v[F_RTS]  = auto_rts_i & rts_i & ~rts_d;       clr_v[F_RTS]  = msr_rd_i;
    set_v[F_CTS]  = auto_cts_i & cts_i & ~cts_d;       clr_v[F_CTS]  = msr_rd_i;
  end

  for (genvar g = 0; g < NFLAG; g++) begin : g_flag
    uirq_flag u_flag (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .set_i (set_v[g]),
      .clr_i (clr_v[g]),
      .q_o   (flag_q[g])
    );
  end

  uirq_timeout #(.CHAR_BITS(CHAR_BITS)) u_to (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .nz_i     (rx_lvl_i != '0),
    .restart_i(rx_char_i | rhr_rd_i),
    .tick_i   (bit_tick_i),
    .rhr_rd_i (rhr_rd_i),
    .pend_o   (to_q)
  );

  assign lvl_req[SRC_LS]  = flag_q[F_LS] & en_ls;
  assign lvl_req[SRC_TO]  = to_q & en_rx;
  assign lvl_req[SRC_RXD] = rxd_q & en_rx;
  assign lvl_req[SRC_TX]  = flag_q[F_TX] & en_tx;
  assign lvl_req[SRC_MS]  = flag_q[F_MS] & en_ms;
  assign lvl_req[SRC_XS]  = (flag_q[F_XOFF] | flag_q[F_SPC]) & en_xs;
  assign lvl_req[SRC_FC]  = (flag_q[F_RTS] & en_rts) | (flag_q[F_CTS] & en_cts);

  uirq_prio u_prio (
    .req_i (lvl_req),
    .src_o (shown),
    .code_o(isr_o)
  );

  assign irq_o = irq_q;

  p_ext_gate_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ext_en_i |-> (isr_o != CODE_XS && isr_o != CODE_FC));
  p_lsr_clr_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lsr_rd_i && !lsr_evt_i) |=> isr_o != CODE_LS);
  p_tx_clr_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (thr_wr_i && !tx_evt_i) |=> !flag_q[F_TX]);
  p_ms_clr_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (msr_rd_i && !msr_evt_i) |=> isr_o != CODE_MS);
  p_irq_reg_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> irq_o == ($past(isr_o) != CODE_NONE));
endmodule

// File: tb/tb_uirq_top.sv
`timescale 1ns/1ps
module tb_uirq_top;
  localparam int LVL_W = 7;
  localparam int TO_N  = 52;

  logic clk_i = 0, rst_ni = 0;
  logic [7:0] ier_i = 8'hFF;
  logic ext_en_i = 1;
  logic lsr_evt_i = 0, lsr_rd_i = 0, rx_char_i = 0, rhr_rd_i = 0, bit_tick_i = 0;
  logic [LVL_W-1:0] rx_lvl_i = 0, rx_trig_i = 4;
  logic tx_evt_i = 0, thr_wr_i = 0, msr_evt_i = 0, msr_rd_i = 0;
  logic xoff_evt_i = 0, xon_evt_i = 0, spc_evt_i = 0;
  logic rts_i = 1, cts_i = 1, auto_rts_i = 1, auto_cts_i = 1, isr_rd_i = 0;
  logic [5:0] isr_o;
  logic irq_o;

  always #2.5 clk_i = ~clk_i;

  uirq_top dut (.*);

  int n_vec = 0, n_bad = 0;
  string cur_req = "R11";
  bit done = 0;

  // behavioural model
  bit m_ls, m_rxd, m_to, m_tx, m_ms, m_xoff, m_spc, m_rts, m_cts, m_irq;
  bit m_rts_prev = 1, m_cts_prev = 1;
  int m_ticks;

  function automatic logic [5:0] exp_code();
    bit x = ext_en_i;
    if (m_ls && ier_i[2]) return 6'h06;
    if (m_to && ier_i[0]) return 6'h0C;
    if (m_rxd && ier_i[0]) return 6'h04;
    if (m_tx && ier_i[1]) return 6'h02;
    if (m_ms && ier_i[3]) return 6'h00;
    if ((m_xoff || m_spc) && ier_i[5] && x) return 6'h10;
    if ((m_rts && ier_i[6] && x) || (m_cts && ier_i[7] && x)) return 6'h20;
    return 6'h01;
  endfunction

  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      {m_ls, m_rxd, m_to, m_tx, m_ms, m_xoff, m_spc, m_rts, m_cts, m_irq} <= '0;
      m_rts_prev <= 1; m_cts_prev <= 1; m_ticks <= 0;
    end else begin
      logic [5:0] c;
      c = exp_code();
      m_irq <= (c != 6'h01);
      m_ls  <= lsr_evt_i ? 1 : (lsr_rd_i ? 0 : m_ls);
      m_rxd <= (rx_lvl_i >= rx_trig_i);
      m_tx  <= tx_evt_i ? 1 : ((thr_wr_i || (isr_rd_i && c == 6'h02)) ? 0 : m_tx);
      m_ms  <= msr_evt_i ? 1 : (msr_rd_i ? 0 : m_ms);
      m_xoff <= xoff_evt_i ? 1 : ((xon_evt_i || (isr_rd_i && c == 6'h10)) ? 0 : m_xoff);
      m_spc  <= spc_evt_i ? 1 : ((rx_char_i || (isr_rd_i && c == 6'h10)) ? 0 : m_spc);
      m_rts <= (auto_rts_i && rts_i && !m_rts_prev) ? 1 : (msr_rd_i ? 0 : m_rts);
      m_cts <= (auto_cts_i && cts_i && !m_cts_prev) ? 1 : (msr_rd_i ? 0 : m_cts);
      m_rts_prev <= rts_i;
      m_cts_prev <= cts_i;
      if (rx_lvl_i == 0 || rx_char_i || rhr_rd_i) m_ticks <= 0;
      else if (bit_tick_i) begin
        m_ticks <= m_ticks + 1;
        if (m_ticks + 1 == TO_N) m_to <= 1;
      end
      if (rhr_rd_i) m_to <= 0;
    end
  end

  // compare every cycle, 1 ns after the rising edge
  always @(posedge clk_i) begin
    #1;
    if (rst_ni && !done) begin
      logic [5:0] e;
      e = exp_code();
      n_vec++;
      if (isr_o !== e) begin
        n_bad++;
        $display("FAIL %s isr_o got %h exp %h", cur_req, isr_o, e);
      end
      if (irq_o !== m_irq) begin
        n_bad++;
        $display("FAIL %s irq_o got %b exp %b", cur_req, irq_o, m_irq);
      end
    end
  end

  task automatic cyc(int n = 1);
    repeat (n) @(negedge clk_i);
  endtask

  task automatic finish_run();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  endtask

  initial begin
    #200000;
    n_bad++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    // R11: reset state and idle code
    cyc(3); rst_ni = 1; cyc(4);

    // R3: set, clear, set beats clear
    cur_req = "R3";
    lsr_evt_i = 1; cyc(); lsr_evt_i = 0; cyc(2);
    lsr_rd_i = 1; cyc(); lsr_rd_i = 0; cyc(2);
    lsr_evt_i = 1; cyc(); lsr_evt_i = 0; cyc();
    lsr_evt_i = 1; lsr_rd_i = 1; cyc(); lsr_evt_i = 0; lsr_rd_i = 0; cyc(2);
    lsr_rd_i = 1; cyc(); lsr_rd_i = 0; cyc(2);

    // R2 R12: stacked causes, serviced in rank order
    cur_req = "R2";
    tx_evt_i = 1; msr_evt_i = 1; xoff_evt_i = 1; lsr_evt_i = 1; cyc();
    tx_evt_i = 0; msr_evt_i = 0; xoff_evt_i = 0; lsr_evt_i = 0; cyc(2);
    lsr_rd_i = 1; cyc(); lsr_rd_i = 0; cyc();
    isr_rd_i = 1; cyc(); isr_rd_i = 0; cyc();       // clears TX only (R6)
    msr_rd_i = 1; cyc(); msr_rd_i = 0; cyc();       // R7
    isr_rd_i = 1; xoff_evt_i = 1; cyc(); xoff_evt_i = 0; isr_rd_i = 0; cyc(); // R8 set wins
    cur_req = "R8";
    isr_rd_i = 1; cyc(); isr_rd_i = 0; cyc(2);

    // R4: trigger level crossing
    cur_req = "R4";
    rx_lvl_i = 3; cyc(2); rx_lvl_i = 4; cyc(3); rx_lvl_i = 5; cyc(2);
    rx_lvl_i = 3; cyc(3);

    // R5: idle timeout with restart
    cur_req = "R5";
    rx_lvl_i = 1; bit_tick_i = 1; cyc(30);
    rx_char_i = 1; rx_lvl_i = 2; cyc(); rx_char_i = 0;
    cyc(TO_N + 4);
    bit_tick_i = 0; cyc(2);
    rhr_rd_i = 1; rx_lvl_i = 1; cyc(); rhr_rd_i = 0; cyc(2);
    rx_lvl_i = 0; bit_tick_i = 1; cyc(TO_N + 4); bit_tick_i = 0; cyc(2);

    // R6: THR write clears TX
    cur_req = "R6";
    tx_evt_i = 1; cyc(); tx_evt_i = 0; cyc(2);
    thr_wr_i = 1; cyc(); thr_wr_i = 0; cyc(2);

    // R8: special char cleared by next rx char; Xoff by Xon
    cur_req = "R8";
    spc_evt_i = 1; cyc(); spc_evt_i = 0; cyc(2);
    rx_char_i = 1; cyc(); rx_char_i = 0; cyc(2);
    xoff_evt_i = 1; cyc(); xoff_evt_i = 0; cyc(2);
    xon_evt_i = 1; cyc(); xon_evt_i = 0; cyc(2);

    // R9: pin rising edges, gated by auto flow control
    cur_req = "R9";
    rts_i = 0; cyc(2); rts_i = 1; cyc(3);
    msr_rd_i = 1; cyc(); msr_rd_i = 0; cyc(2);
    auto_cts_i = 0; cts_i = 0; cyc(2); cts_i = 1; cyc(3);
    auto_cts_i = 1; cts_i = 0; cyc(2); cts_i = 1; cyc(3);
    msr_rd_i = 1; cyc(); msr_rd_i = 0; cyc(2);

    // R1: extended enables need ext_en_i
    cur_req = "R1";
    xoff_evt_i = 1; cyc(); xoff_evt_i = 0; cyc(2);
    ext_en_i = 0; cyc(3);
    rts_i = 0; cyc(); rts_i = 1; cyc(3);
    ext_en_i = 1; cyc(3);

    // R10: masking keeps pending state, irq follows one cycle later
    cur_req = "R10";
    ier_i = 8'h00; cyc(3);
    tx_evt_i = 1; cyc(); tx_evt_i = 0; cyc(3);
    ier_i = 8'h02; cyc(3);
    ier_i = 8'hFF; cyc(2);
    isr_rd_i = 1; cyc(); isr_rd_i = 0; cyc();
    msr_rd_i = 1; isr_rd_i = 1; cyc(); msr_rd_i = 0; isr_rd_i = 0; cyc(3);

    cur_req = "R11";
    cyc(4);
    finish_run();
  end
endmodule